// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block turns a 32-bit virtual address into a physical address for whichever address space is running now. It holds a small set of page mappings. All of them are compared at once against the virtual page number and the current address-space identifier. Each mapping also carries its own privilege bits, which are checked against the current processor mode. Every lookup reports exactly one of three outcomes: a hit with a translated address, a miss, or a permission fault.

The hardware never walks page tables. When a lookup misses, system software installs the mapping through a write port. It may name the slot to use, or leave the choice to the block, which then takes a pseudo-random slot from a free-running shift register. A separate one-cycle flush clears every mapping. Pages are 4 KB, so the low 12 address bits pass through unchanged.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is invalid and `rsp_valid` is 0, so any lookup made right after reset misses.
- R2: A lookup hits only when a slot is valid, its stored page number equals `lk_vaddr[31:12]` and its stored identifier equals `cur_asid`. On a permitted hit, `rsp_paddr` is {stored frame, `lk_vaddr[11:0]`}, and it appears on the clock edge that follows the request.
- R3: A slot whose page number matches but whose identifier differs from `cur_asid` does not hit, so the same virtual page can map to different frames in different address spaces.
- R4: The mode is encoded as 0 user, 1 supervisor, 2 kernel, and 3, which is treated as user. Kernel mode may use any hit. Supervisor mode needs the slot's `sup_ok` bit. User mode needs the slot's `usr_ok` bit. A matching slot that the current mode may not use gives `rsp_fault`=1 and `rsp_hit`=0.
- R5: When `rsp_valid` is 1, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is set. `rsp_paddr` is 0 unless `rsp_hit` is set.
- R6: A write with `wr_en`=1 and `wr_use_idx`=1 installs a valid mapping in slot `wr_idx`, and that mapping is visible from the next cycle onward.
- R7: A write with `wr_use_idx`=0 replaces exactly one slot, picked by a pseudo-random generator that advances every cycle. All other slots keep their mappings.
- R8: `flush_all` clears every valid bit in one cycle. A write in the same cycle as a flush is dropped.
- R9: A lookup made in the same cycle as a write sees the table as it stood before that write.
- R10: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_valid`=1, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_asid | input | 8 | Identifier of the running address space |
| cur_mode | input | 2 | Current privilege mode (0 user, 1 supervisor, 2 kernel, 3 treated as user) |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| wr_en | input | 1 | Install a mapping |
| wr_use_idx | input | 1 | 1: use `wr_idx`; 0: random slot |
| wr_idx | input | 4 | Explicit slot number |
| wr_vpn | input | 20 | Virtual page number to install |
| wr_asid | input | 8 | Address-space identifier to install |
| wr_pfn | input | 20 | Physical frame number to install |
| wr_usr_ok | input | 1 | User mode may use this mapping |
| wr_sup_ok | input | 1 | Supervisor mode may use this mapping |
| flush_all | input | 1 | Invalidate every slot |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Permitted translation |
| rsp_miss | output | 1 | No matching slot |
| rsp_fault | output | 1 | Matching slot, but the mode lacks permission |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
The bench fills every slot with a distinct page number, identifier and pair of permission bits. It then looks up each slot in every mode and under a wrong identifier. A design that ignored the identifier would hit when it should miss. A design that decoded the mode wrongly would fault where it should hit, or hit where it should fault. A random fill into a full table must knock out exactly one old mapping; a design that ignored the random slot would leave a different number of old mappings alive, or leave the new one unreachable. Lookups in the same cycle as a write, and writes in the same cycle as a flush, show whether the design honours the write timing and the flush priority.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    MODE_USER   = 2'd0,
    MODE_SUPER  = 2'd1,
    MODE_KERNEL = 2'd2,
    MODE_RSVD   = 2'd3
  } priv_mode_e;

  // Kernel may use anything; supervisor needs sup_ok; user and reserved need usr_ok.
  function automatic logic mode_allows(input logic [1:0] mode,
                                       input logic usr_ok,
                                       input logic sup_ok);
    case (mode)
      MODE_KERNEL: return 1'b1;
      MODE_SUPER:  return sup_ok;
      default:     return usr_ok;
    endcase
  endfunction
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h5A
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= {state[W-2:0], fb};
  end

  // R7: the generator must never lock up in the all-zero state
  p_lfsr_nonzero_r7: assert property (@(posedge clk) disable iff (rst) state != '0);
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_all,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_slot,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_usr_ok,
  input  logic              wr_sup_ok,
  output logic [ENTRIES-1:0] valid_q,
  output logic [VPN_W-1:0]  vpn_q  [ENTRIES],
  output logic [ASID_W-1:0] asid_q [ENTRIES],
  output logic [PFN_W-1:0]  pfn_q  [ENTRIES],
  output logic [ENTRIES-1:0] usr_q,
  output logic [ENTRIES-1:0] sup_q
);
  logic do_write;
  assign do_write = wr_en && !flush_all;

  always_ff @(posedge clk) begin
    if (rst || flush_all) valid_q <= '0;
    else if (wr_en) valid_q[wr_slot] <= 1'b1;
  end

  // Payload has no reset; only the valid bits qualify it.
  always_ff @(posedge clk) begin
    if (do_write) begin
      vpn_q[wr_slot]  <= wr_vpn;
      asid_q[wr_slot] <= wr_asid;
      pfn_q[wr_slot]  <= wr_pfn;
      usr_q[wr_slot]  <= wr_usr_ok;
      sup_q[wr_slot]  <= wr_sup_ok;
    end
  end

  // R8: a flush leaves no valid slot behind
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
    $past(flush_all) |-> (valid_q == '0));
  // R6: an accepted write leaves its slot valid
  p_write_sets_valid_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(do_write) && !$past(rst)) |-> valid_q[$past(wr_slot)]);
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic [ENTRIES-1:0] valid_q,
  input  logic [VPN_W-1:0]  vpn_q  [ENTRIES],
  input  logic [ASID_W-1:0] asid_q [ENTRIES],
  input  logic [PFN_W-1:0]  pfn_q  [ENTRIES],
  input  logic [ENTRIES-1:0] usr_q,
  input  logic [ENTRIES-1:0] sup_q,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              any_match,
  output logic [PFN_W-1:0]  sel_pfn,
  output logic              sel_usr,
  output logic              sel_sup
);
  logic [ENTRIES-1:0] match_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn) && (asid_q[g] == lk_asid);
  end

  // Lowest matching slot wins if software left duplicates.
  always_comb begin
    any_match = 1'b0;
    sel_pfn   = '0;
    sel_usr   = 1'b0;
    sel_sup   = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        any_match = 1'b1;
        sel_pfn   = pfn_q[i];
        sel_usr   = usr_q[i];
        sel_sup   = sup_q[i];
      end
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int ASID_W  = 8,
  parameter int ENTRIES = 16,
  parameter int RND_W   = 8,
  localparam int VPN_W  = VA_W - PAGE_W,
  localparam int PFN_W  = PA_W - PAGE_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [1:0]        cur_mode,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              wr_en,
  input  logic              wr_use_idx,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_usr_ok,
  input  logic              wr_sup_ok,
  input  logic              flush_all,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr
);
  import tlb_pkg::*;

  logic [RND_W-1:0]  rnd_state;
  logic [IDX_W-1:0]  wr_slot;
  logic [ENTRIES-1:0] valid_q, usr_q, sup_q;
  logic [VPN_W-1:0]  vpn_q  [ENTRIES];
  logic [ASID_W-1:0] asid_q [ENTRIES];
  logic [PFN_W-1:0]  pfn_q  [ENTRIES];
  logic              any_match, sel_usr, sel_sup, allowed;
  logic [PFN_W-1:0]  sel_pfn;

  tlb_lfsr #(.W(RND_W)) u_rnd (.clk(clk), .rst(rst), .state(rnd_state));

  assign wr_slot = wr_use_idx ? wr_idx : rnd_state[IDX_W-1:0];

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_store (
    .clk(clk), .rst(rst), .flush_all(flush_all),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_pfn(wr_pfn), .wr_usr_ok(wr_usr_ok), .wr_sup_ok(wr_sup_ok),
    .valid_q(valid_q), .vpn_q(vpn_q), .asid_q(asid_q), .pfn_q(pfn_q),
    .usr_q(usr_q), .sup_q(sup_q)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_match (
    .valid_q(valid_q), .vpn_q(vpn_q), .asid_q(asid_q), .pfn_q(pfn_q),
    .usr_q(usr_q), .sup_q(sup_q),
    .lk_vpn(lk_vaddr[VA_W-1:PAGE_W]), .lk_asid(cur_asid),
    .any_match(any_match), .sel_pfn(sel_pfn), .sel_usr(sel_usr), .sel_sup(sel_sup)
  );

  assign allowed = mode_allows(cur_mode, sel_usr, sel_sup);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && any_match && allowed;
      rsp_miss  <= lk_valid && !any_match;
      rsp_fault <= lk_valid && any_match && !allowed;
      rsp_paddr <= (lk_valid && any_match && allowed)
                   ? {sel_pfn, lk_vaddr[PAGE_W-1:0]} : '0;
    end
  end

  // R10: a response follows each request by one cycle, never otherwise
  p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == ($past(lk_valid) && !$past(rst)));
  // R5: one outcome per response, none when idle
  p_one_outcome_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid ? $onehot({rsp_hit, rsp_miss, rsp_fault})
              : ({rsp_hit, rsp_miss, rsp_fault} == 3'b000));
  // R5: no address leaks out without a permitted hit
  p_no_addr_on_reject_r5: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_paddr == '0));
  // R2: page offset passes through untouched
  p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_paddr[PAGE_W-1:0] == $past(lk_vaddr[PAGE_W-1:0])));
  // R4: kernel mode never faults
  p_kernel_no_fault_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(rst) && $past(cur_mode) == 2'd2) |-> !rsp_fault);
endmodule

// File: tb/asid_tlb_tb_top.sv
module asid_tlb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  cur_asid = '0;
  logic [1:0]  cur_mode = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        wr_en = 1'b0, wr_use_idx = 1'b0, wr_usr_ok = 1'b0, wr_sup_ok = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [19:0] wr_vpn = '0, wr_pfn = '0;
  logic [7:0]  wr_asid = '0;
  logic        flush_all = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_paddr;

  int checks = 0;
  int errors = 0;

  // bench-side model of installed mappings
  logic [19:0] m_vpn [N];
  logic [7:0]  m_asid [N];
  logic [19:0] m_pfn [N];
  logic        m_usr [N], m_sup [N], m_val [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb dut_i (
    .clk(clk), .rst(rst), .cur_asid(cur_asid), .cur_mode(cur_mode),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .wr_en(wr_en), .wr_use_idx(wr_use_idx), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_asid(wr_asid), .wr_pfn(wr_pfn), .wr_usr_ok(wr_usr_ok), .wr_sup_ok(wr_sup_ok),
    .flush_all(flush_all),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // outcome packed as {valid,hit,miss,fault,paddr}
  function automatic logic [35:0] expect_of(input logic [31:0] va, input logic [7:0] asid,
                                            input logic [1:0] mode);
    for (int i = 0; i < N; i++) begin
      if (m_val[i] && m_vpn[i] == va[31:12] && m_asid[i] == asid) begin
        logic ok;
        ok = (mode == 2'd2) ? 1'b1 : (mode == 2'd1) ? m_sup[i] : m_usr[i];
        return ok ? {4'b1100, m_pfn[i], va[11:0]} : {4'b1001, 32'h0};
      end
    end
    return {4'b1010, 32'h0};
  endfunction

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] mode,
                        output logic [35:0] got);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; cur_asid = asid; cur_mode = mode;
    @(negedge clk);
    lk_valid = 1'b0;
    got = {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr};
  endtask

  task automatic write(input logic use_idx, input logic [3:0] idx, input logic [19:0] vpn,
                       input logic [7:0] asid, input logic [19:0] pfn,
                       input logic u, input logic s);
    @(negedge clk);
    wr_en = 1'b1; wr_use_idx = use_idx; wr_idx = idx; wr_vpn = vpn; wr_asid = asid;
    wr_pfn = pfn; wr_usr_ok = u; wr_sup_ok = s;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [35:0] got;
    int survivors, newhits, lost;
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rsp_valid after reset", {35'h0, rsp_valid}, 36'h0);
    lookup(32'h0000_0123, 8'h00, 2'd2, got);
    chk("R1 lookup after reset misses", got, {4'b1010, 32'h0});
    @(negedge clk);
    chk("R10 idle cycle no response", {35'h0, rsp_valid}, 36'h0);

    // R6: fill each slot by index with distinct contents
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = 20'h1000 + 20'(i) * 20'h111;
      m_asid[i] = 8'(i % 4) + 8'h10;
      m_pfn[i] = 20'h80000 + 20'(i) * 20'h3;
      m_usr[i] = i[0]; m_sup[i] = i[1]; m_val[i] = 1'b1;
      write(1'b1, 4'(i), m_vpn[i], m_asid[i], m_pfn[i], m_usr[i], m_sup[i]);
    end
    // R2/R4: every slot in every mode, R3: wrong identifier
    for (int i = 0; i < N; i++) begin
      for (int md = 0; md < 4; md++) begin
        logic [31:0] va;
        va = {m_vpn[i], 12'(i * 37 + md)};
        lookup(va, m_asid[i], 2'(md), got);
        chk("R2/R4 sweep lookup", got, expect_of(va, m_asid[i], 2'(md)));
      end
      lookup({m_vpn[i], 12'hFFF}, m_asid[i] ^ 8'h80, 2'd2, got);
      chk("R3 wrong identifier misses", got, {4'b1010, 32'h0});
    end
    // R3: same page, second address space, different frame
    m_vpn[3] = m_vpn[2]; m_asid[3] = 8'h33; m_pfn[3] = 20'h0BEEF; m_usr[3] = 1'b1; m_sup[3] = 1'b1;
    write(1'b1, 4'd3, m_vpn[3], m_asid[3], m_pfn[3], 1'b1, 1'b1);
    lookup({m_vpn[2], 12'h044}, m_asid[2], 2'd2, got);
    chk("R3 space A frame", got, {4'b1100, m_pfn[2], 12'h044});
    lookup({m_vpn[2], 12'h044}, 8'h33, 2'd2, got);
    chk("R3 space B frame", got, {4'b1100, 20'h0BEEF, 12'h044});
    // R5: unmapped page
    lookup(32'hFFFF_F000, 8'h10, 2'd2, got);
    chk("R5 unmapped miss", got, {4'b1010, 32'h0});

    // R7: random fill into a full table replaces exactly one slot
    write(1'b0, 4'd0, 20'hABCDE, 8'h77, 20'h12345, 1'b1, 1'b1);
    survivors = 0; lost = -1;
    for (int i = 0; i < N; i++) begin
      lookup({m_vpn[i], 12'h0}, m_asid[i], 2'd2, got);
      if (got[34]) survivors++; else lost = i;
    end
    chk("R7 one slot replaced", 36'(survivors), 36'(N - 1));
    lookup(32'hABCD_E5A5, 8'h77, 2'd0, got);
    newhits = got[34] ? 1 : 0;
    chk("R7 new mapping reachable", got, {4'b1100, 20'h12345, 12'h5A5});
    if (lost >= 0) begin
      m_vpn[lost] = 20'hABCDE; m_asid[lost] = 8'h77; m_pfn[lost] = 20'h12345;
      m_usr[lost] = 1'b1; m_sup[lost] = 1'b1;
    end

    // R9: lookup in the same cycle as a write sees old contents
    @(negedge clk);
    wr_en = 1'b1; wr_use_idx = 1'b1; wr_idx = 4'd5; wr_vpn = 20'h55555; wr_asid = 8'h55;
    wr_pfn = 20'h0AAAA; wr_usr_ok = 1'b1; wr_sup_ok = 1'b0;
    lk_valid = 1'b1; lk_vaddr = 32'h5555_5010; cur_asid = 8'h55; cur_mode = 2'd0;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    chk("R9 same-cycle lookup sees old table",
        {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr}, {4'b1010, 32'h0});
    lookup(32'h5555_5010, 8'h55, 2'd0, got);
    chk("R9/R6 next cycle sees write", got, {4'b1100, 20'h0AAAA, 12'h010});
    lookup(32'h5555_5010, 8'h55, 2'd1, got);
    chk("R4 supervisor without sup_ok faults", got, {4'b1001, 32'h0});
    lookup(32'h5555_5010, 8'h55, 2'd3, got);
    chk("R4 mode 3 acts as user", got, {4'b1100, 20'h0AAAA, 12'h010});

    // R8: flush clears all, and beats a same-cycle write
    @(negedge clk);
    flush_all = 1'b1; wr_en = 1'b1; wr_use_idx = 1'b1; wr_idx = 4'd9; wr_vpn = 20'h99999;
    wr_asid = 8'h99; wr_pfn = 20'h09999; wr_usr_ok = 1'b1; wr_sup_ok = 1'b1;
    @(negedge clk);
    flush_all = 1'b0; wr_en = 1'b0;
    lookup(32'h9999_9000, 8'h99, 2'd2, got);
    chk("R8 write dropped during flush", got, {4'b1010, 32'h0});
    survivors = 0;
    for (int i = 0; i < N; i++) begin
      lookup({m_vpn[i], 12'h0}, m_asid[i], 2'd2, got);
      if (got[34] || got[32]) survivors++;
    end
    chk("R8 nothing survives flush", 36'(survivors), 36'h0);
    @(negedge clk);
    chk("R10 no response without request", {35'h0, rsp_valid}, 36'h0);
    if (newhits == 0) $display("note: random mapping not reached");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule